// File: doc/BRIEF.md
# Transactional Data Cache with Read/Write-Set Conflict Detection

This block is a small direct-mapped data cache for one processor running a hardware transaction. Every word in the cache has two tracking bits. One records that the transaction has loaded the word (its read-set). The other records that the transaction has stored to it (its write-set). Stores are kept in the cache as speculative data, so memory is only updated after commit, which is lazy versioning. A commit pulse clears every tracking bit in one cycle. Written lines stay valid and dirty, so the update is logical and nothing is written back at that point. An abort pulse invalidates every line that holds a tracking bit and clears all the bits. The next attempt of the transaction then refetches current data.

Incoming coherence requests from other agents are either shared or exclusive, and each names one word. The block checks each request against the tracking bits and reports a classified conflict one cycle later. Deciding what to do about a conflict belongs to a contention manager outside this block. Misses go to memory through a single request/acknowledge handshake. That handshake carries the writeback of a dirty victim and returns a whole line.

There are two things the cache will not do. It never evicts a line that carries tracking bits: such an access is refused with an overflow flag. Before the transaction first touches a line that is dirty with committed data, the cache writes that line back. Because of this, an abort can never destroy committed data.

Top module: `tcache_top`

## Requirements
- R1: A processor load that completes without overflow marks the loaded word as read by the transaction.
- R2: A shared coherence request to a word the transaction has stored reports a read-write conflict, `conf_kind` = 1.
- R3: An exclusive coherence request to a word the transaction has stored reports a write-write conflict, `conf_kind` = 2. This takes priority over the read case.
- R4: An exclusive coherence request to a word that was only read reports a write-read conflict, `conf_kind` = 3. A shared request to such a word reports nothing.
- R5: A coherence request that matches no tracking bit (wrong tag, untouched word, or invalid line) raises no conflict. The cache contents stay as they were: later loads hit with the same data and issue no memory request.
- R6: A `tx_commit` pulse clears every tracking bit. Speculatively written lines stay valid and dirty, and no writeback is issued at commit.
- R7: A `tx_abort` pulse clears every tracking bit and invalidates every line that held one. The next load of such a word misses and returns the memory value.
- R8: A miss whose target line holds tracking bits is refused with `resp_ovf` = 1. The refusal issues no memory request and leaves the tracking state intact.
- R9: A miss raises `mem_req` with the line address `mem_addr` (word address without the 2 offset bits). `mem_req`, `mem_addr` and the writeback fields hold steady until `mem_ack`. When the victim is valid and dirty, `mem_wb` = 1 and `mem_wb_addr`/`mem_wb_data` carry it. Word w of a line sits at bits [32w+31:32w].
- R10: The first transactional access to a line that is dirty and untracked first writes the line back and refills it. Only after that is the access served.
- R11: A hit returns `resp_valid` one cycle after the request is accepted. A conflict result appears one cycle after `coh_valid`.
- R12: After reset all lines are invalid and untracked, and `resp_valid`, `mem_req` and `conf_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor access request, held until `resp_valid` |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 12 | Word address (tag, 3-bit index, 2-bit offset) |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | One-cycle completion pulse |
| resp_ovf | output | 1 | Access refused because a tracked line would be evicted |
| resp_rdata | output | 32 | Load data |
| tx_commit | input | 1 | Commit pulse |
| tx_abort | input | 1 | Abort pulse (wins over commit) |
| coh_valid | input | 1 | Incoming coherence request |
| coh_excl | input | 1 | 1 = exclusive, 0 = shared |
| coh_addr | input | 12 | Word address of the coherence request |
| conf_valid | output | 1 | Conflict detected |
| conf_kind | output | 2 | 1 read-write, 2 write-write, 3 write-read |
| mem_req | output | 1 | Line refill request |
| mem_addr | output | 10 | Line address to fetch |
| mem_wb | output | 1 | Victim writeback accompanies the request |
| mem_wb_addr | output | 10 | Line address of the victim |
| mem_wb_data | output | 128 | Victim line data |
| mem_ack | input | 1 | Memory done; fill data valid this cycle |
| mem_fill_data | input | 128 | Fill line data |

## Verification
Each result has a fixed due cycle. A hit completes on the first falling edge after its request is driven. A conflict verdict is read on the falling edge after the cycle in which `coh_valid` was high. Misses and cleaning writebacks take however long the bench's memory model delays `mem_ack`, so access tasks wait for `resp_valid` and report the number of cycles it took. Hit latency is checked exactly against one cycle. Expected load data, overflow refusals and conflict kinds come from an architectural model that tracks committed and speculative values, read/write sets and which index holds a tracked line. The model does not reproduce the cache's internal structure.

// File: rtl/tcache_pkg.sv
package tcache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MISS = 2'd1,
    ST_DONE = 2'd2
  } tc_state_e;

  typedef enum logic [1:0] {
    CK_NONE = 2'd0,
    CK_RW   = 2'd1,
    CK_WW   = 2'd2,
    CK_WR   = 2'd3
  } tc_conf_e;

endpackage

// File: rtl/tcache_lines.sv
module tcache_lines #(
  parameter int LINES = 8,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  parameter int TW    = 7
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [$clog2(LINES)-1:0]          rd_idx,
  output logic                              rd_valid,
  output logic [TW-1:0]                     rd_tag,
  output logic                              rd_dirty,
  output logic [WORDS-1:0][DW-1:0]          rd_line,
  input  logic [$clog2(LINES)-1:0]          sn_idx,
  output logic                              sn_valid,
  output logic [TW-1:0]                     sn_tag,
  input  logic                              wr_en,
  input  logic [$clog2(LINES)-1:0]          wr_idx,
  input  logic [$clog2(WORDS)-1:0]          wr_off,
  input  logic [DW-1:0]                     wr_data,
  input  logic                              fill_en,
  input  logic [$clog2(LINES)-1:0]          fill_idx,
  input  logic [TW-1:0]                     fill_tag,
  input  logic [WORDS-1:0][DW-1:0]          fill_line,
  input  logic [LINES-1:0]                  inv_mask
);
  localparam int IB = $clog2(LINES);

  logic [WORDS-1:0][DW-1:0] data_q [LINES];
  logic [LINES-1:0]         valid_q;
  logic [LINES-1:0]         dirty_q;
  logic [TW-1:0]            tag_q [LINES];

  always_ff @(posedge clk) begin
    if (fill_en)
      data_q[fill_idx] <= fill_line;
    else if (wr_en)
      data_q[wr_idx][wr_off] <= wr_data;
  end

  for (genvar k = 0; k < LINES; k++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q[k] <= 1'b0;
        dirty_q[k] <= 1'b0;
        tag_q[k]   <= '0;
      end else if (fill_en && fill_idx == IB'(k)) begin
        valid_q[k] <= 1'b1;
        dirty_q[k] <= 1'b0;
        tag_q[k]   <= fill_tag;
      end else if (inv_mask[k]) begin
        valid_q[k] <= 1'b0;
        dirty_q[k] <= 1'b0;
      end else if (wr_en && wr_idx == IB'(k)) begin
        dirty_q[k] <= 1'b1;
      end
    end

    // R7
    abort_invalidates_chk: assert property (@(posedge clk) disable iff (rst)
      (inv_mask[k] && !(fill_en && fill_idx == IB'(k))) |=> !valid_q[k]);
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_dirty = dirty_q[rd_idx];
  assign rd_line  = data_q[rd_idx];
  assign sn_valid = valid_q[sn_idx];
  assign sn_tag   = tag_q[sn_idx];

endmodule

// File: rtl/tcache_track.sv
module tcache_track #(
  parameter int LINES = 8,
  parameter int WORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     set_r,
  input  logic                     set_w,
  input  logic [$clog2(LINES)-1:0] set_idx,
  input  logic [$clog2(WORDS)-1:0] set_off,
  output logic                     cpu_tracked,
  output logic [LINES-1:0]         trk_mask,
  input  logic [$clog2(LINES)-1:0] sn_idx,
  input  logic [$clog2(WORDS)-1:0] sn_off,
  output logic                     sn_r,
  output logic                     sn_w
);
  logic [LINES-1:0][WORDS-1:0] r_q;
  logic [LINES-1:0][WORDS-1:0] w_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      r_q <= '0;
      w_q <= '0;
    end else begin
      if (set_r) r_q[set_idx][set_off] <= 1'b1;
      if (set_w) w_q[set_idx][set_off] <= 1'b1;
    end
  end

  for (genvar k = 0; k < LINES; k++) begin : g_mask
    assign trk_mask[k] = |(r_q[k] | w_q[k]);
  end

  assign cpu_tracked = trk_mask[set_idx];
  assign sn_r        = r_q[sn_idx][sn_off];
  assign sn_w        = w_q[sn_idx][sn_off];

  // R6
  gang_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (r_q == '0 && w_q == '0));

  // R1
  read_mark_chk: assert property (@(posedge clk) disable iff (rst)
    (set_r && !clr) |=> r_q[$past(set_idx)][$past(set_off)]);

endmodule

// File: rtl/tcache_snoop.sv
module tcache_snoop
  import tcache_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       coh_valid,
  input  logic       coh_excl,
  input  logic       hit,
  input  logic       r_bit,
  input  logic       w_bit,
  output logic       conf_valid,
  output logic [1:0] conf_kind
);
  tc_conf_e kind_c;

  always_comb begin
    kind_c = CK_NONE;
    if (coh_valid && hit) begin
      if (w_bit)
        kind_c = coh_excl ? CK_WW : CK_RW;
      else if (r_bit && coh_excl)
        kind_c = CK_WR;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      conf_valid <= 1'b0;
      conf_kind  <= CK_NONE;
    end else begin
      conf_valid <= (kind_c != CK_NONE);
      conf_kind  <= kind_c;
    end
  end

  // R11
  conf_latency_chk: assert property (@(posedge clk) disable iff (rst)
    conf_valid |-> $past(coh_valid));

  // R3
  ww_priority_chk: assert property (@(posedge clk) disable iff (rst)
    (coh_valid && coh_excl && hit && w_bit) |=> (conf_valid && conf_kind == CK_WW));

endmodule

// File: rtl/tcache_top.sv
module tcache_top
  import tcache_pkg::*;
#(
  parameter int LINES = 8,
  parameter int WORDS = 4,
  parameter int DW    = 32,
  parameter int AW    = 12,
  localparam int IB   = $clog2(LINES),
  localparam int OB   = $clog2(WORDS),
  localparam int TW   = AW - IB - OB,
  localparam int LW   = WORDS * DW,
  localparam int LAW  = AW - OB
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  output logic           resp_valid,
  output logic           resp_ovf,
  output logic [DW-1:0]  resp_rdata,
  input  logic           tx_commit,
  input  logic           tx_abort,
  input  logic           coh_valid,
  input  logic           coh_excl,
  input  logic [AW-1:0]  coh_addr,
  output logic           conf_valid,
  output logic [1:0]     conf_kind,
  output logic           mem_req,
  output logic [LAW-1:0] mem_addr,
  output logic           mem_wb,
  output logic [LAW-1:0] mem_wb_addr,
  output logic [LW-1:0]  mem_wb_data,
  input  logic           mem_ack,
  input  logic [LW-1:0]  mem_fill_data
);
  tc_state_e st_q;

  logic [IB-1:0] idx;
  logic [OB-1:0] off;
  logic [TW-1:0] tg;
  logic [IB-1:0] sn_idx;
  logic [OB-1:0] sn_off;
  logic [TW-1:0] sn_tg;

  assign off    = req_addr[OB-1:0];
  assign idx    = req_addr[OB +: IB];
  assign tg     = req_addr[AW-1 -: TW];
  assign sn_off = coh_addr[OB-1:0];
  assign sn_idx = coh_addr[OB +: IB];
  assign sn_tg  = coh_addr[AW-1 -: TW];

  logic                     line_valid, line_dirty, tracked;
  logic [TW-1:0]            line_tag;
  logic [WORDS-1:0][DW-1:0] line_data;
  logic                     sn_valid, sn_r, sn_w;
  logic [TW-1:0]            sn_tag;
  logic [LINES-1:0]         trk_mask;

  logic hit, go, serve, need_clean, ovf_case, refill;
  logic fill_en, clr;
  logic [LINES-1:0] inv_mask;

  assign hit        = line_valid && (line_tag == tg);
  assign go         = (st_q == ST_IDLE) && req_valid && !tx_commit && !tx_abort;
  assign serve      = go && hit && (!line_dirty || tracked);
  assign need_clean = go && hit && line_dirty && !tracked;
  assign ovf_case   = go && !hit && line_valid && tracked;
  assign refill     = go && !hit && !(line_valid && tracked);
  assign fill_en    = (st_q == ST_MISS) && mem_ack;
  assign clr        = tx_commit || tx_abort;
  assign inv_mask   = tx_abort ? trk_mask : '0;

  tcache_lines #(.LINES(LINES), .WORDS(WORDS), .DW(DW), .TW(TW)) u_lines (
    .clk       (clk),
    .rst       (rst),
    .rd_idx    (idx),
    .rd_valid  (line_valid),
    .rd_tag    (line_tag),
    .rd_dirty  (line_dirty),
    .rd_line   (line_data),
    .sn_idx    (sn_idx),
    .sn_valid  (sn_valid),
    .sn_tag    (sn_tag),
    .wr_en     (serve && req_write),
    .wr_idx    (idx),
    .wr_off    (off),
    .wr_data   (req_wdata),
    .fill_en   (fill_en),
    .fill_idx  (mem_addr[IB-1:0]),
    .fill_tag  (mem_addr[LAW-1:IB]),
    .fill_line (mem_fill_data),
    .inv_mask  (inv_mask)
  );

  tcache_track #(.LINES(LINES), .WORDS(WORDS)) u_track (
    .clk         (clk),
    .rst         (rst),
    .clr         (clr),
    .set_r       (serve && !req_write),
    .set_w       (serve && req_write),
    .set_idx     (idx),
    .set_off     (off),
    .cpu_tracked (tracked),
    .trk_mask    (trk_mask),
    .sn_idx      (sn_idx),
    .sn_off      (sn_off),
    .sn_r        (sn_r),
    .sn_w        (sn_w)
  );

  tcache_snoop u_snoop (
    .clk        (clk),
    .rst        (rst),
    .coh_valid  (coh_valid),
    .coh_excl   (coh_excl),
    .hit        (sn_valid && (sn_tag == sn_tg)),
    .r_bit      (sn_r),
    .w_bit      (sn_w),
    .conf_valid (conf_valid),
    .conf_kind  (conf_kind)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_IDLE;
      resp_valid  <= 1'b0;
      resp_ovf    <= 1'b0;
      resp_rdata  <= '0;
      mem_req     <= 1'b0;
      mem_addr    <= '0;
      mem_wb      <= 1'b0;
      mem_wb_addr <= '0;
      mem_wb_data <= '0;
    end else begin
      resp_valid <= 1'b0;
      resp_ovf   <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (serve) begin
            resp_valid <= 1'b1;
            resp_rdata <= req_write ? req_wdata : line_data[off];
            st_q       <= ST_DONE;
          end else if (ovf_case) begin
            resp_valid <= 1'b1;
            resp_ovf   <= 1'b1;
            st_q       <= ST_DONE;
          end else if (need_clean || refill) begin
            mem_req     <= 1'b1;
            mem_addr    <= req_addr[AW-1:OB];
            mem_wb      <= line_valid && line_dirty;
            mem_wb_addr <= {line_tag, idx};
            mem_wb_data <= line_data;
            st_q        <= ST_MISS;
          end
        end
        ST_MISS: begin
          if (mem_ack) begin
            mem_req <= 1'b0;
            mem_wb  <= 1'b0;
            st_q    <= ST_IDLE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_wb)));

  // R8
  no_evict_tracked_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_case |=> (resp_ovf && resp_valid && !mem_req));

  // R10
  clean_first_chk: assert property (@(posedge clk) disable iff (rst)
    need_clean |=> (mem_req && mem_wb && !resp_valid));

endmodule

// File: tb/tcache_top_tb.sv
module tcache_top_tb;
  localparam int AW = 12;
  localparam int DW = 32;
  localparam int LW = 128;
  localparam int MEMW = 4096;
  localparam int POOL = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic resp_valid, resp_ovf;
  logic [DW-1:0] resp_rdata;
  logic tx_commit = 0, tx_abort = 0;
  logic coh_valid = 0, coh_excl = 0;
  logic [AW-1:0] coh_addr = '0;
  logic conf_valid;
  logic [1:0] conf_kind;
  logic mem_req, mem_wb;
  logic [AW-3:0] mem_addr, mem_wb_addr;
  logic [LW-1:0] mem_wb_data;
  logic mem_ack = 0;
  logic [LW-1:0] mem_fill_data = '0;

  always #10 clk = ~clk;

  tcache_top u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .resp_valid(resp_valid),
    .resp_ovf(resp_ovf), .resp_rdata(resp_rdata), .tx_commit(tx_commit),
    .tx_abort(tx_abort), .coh_valid(coh_valid), .coh_excl(coh_excl),
    .coh_addr(coh_addr), .conf_valid(conf_valid), .conf_kind(conf_kind),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_wb(mem_wb),
    .mem_wb_addr(mem_wb_addr), .mem_wb_data(mem_wb_data),
    .mem_ack(mem_ack), .mem_fill_data(mem_fill_data)
  );

  int n_checks = 0, n_fail = 0;
  int fills = 0, wbs = 0;
  int last_fill_line = -1, last_wb_line = -1;
  logic [DW-1:0] mem_img [MEMW];
  logic [DW-1:0] arch [POOL];
  logic [DW-1:0] spec_d [POOL];
  bit spec_v [POOL];
  bit rset [POOL];
  bit wset [POOL];
  bit trk_on [8];
  int trk_tag [8];

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // memory responder
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req && !mem_ack) begin
        repeat (2) @(negedge clk);
        if (mem_wb) begin
          for (int w = 0; w < 4; w++) mem_img[int'(mem_wb_addr) * 4 + w] = mem_wb_data[w*32 +: 32];
          wbs++;
          last_wb_line = int'(mem_wb_addr);
        end
        for (int w = 0; w < 4; w++) mem_fill_data[w*32 +: 32] = mem_img[int'(mem_addr) * 4 + w];
        fills++;
        last_fill_line = int'(mem_addr);
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
      end
    end
  end

  function automatic bit exp_ovf(input int a);
    int ix = (a >> 2) & 7;
    return trk_on[ix] && trk_tag[ix] != (a >> 5);
  endfunction

  function automatic logic [1:0] exp_kind(input bit ex, input int a);
    if (a >= POOL) return 2'd0;
    if (wset[a]) return ex ? 2'd2 : 2'd1;
    if (rset[a] && ex) return 2'd3;
    return 2'd0;
  endfunction

  task automatic access(input bit wr, input int a, input logic [DW-1:0] wd, output int cyc);
    cyc = 0;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = AW'(a); req_wdata = wd;
    do begin
      @(negedge clk);
      cyc++;
    end while (!resp_valid);
    req_valid = 0;
  endtask

  task automatic op_load(input int a, input string rq, output int cyc);
    bit eo = exp_ovf(a);
    logic [DW-1:0] ev = spec_v[a] ? spec_d[a] : arch[a];
    access(1'b0, a, '0, cyc);
    check(resp_ovf == eo, "R8", resp_ovf, eo);
    if (!eo) begin
      check(resp_rdata == ev, rq, resp_rdata, ev);
      rset[a] = 1; trk_on[(a>>2)&7] = 1; trk_tag[(a>>2)&7] = a >> 5;
    end
  endtask

  task automatic op_store(input int a, input logic [DW-1:0] v, output int cyc);
    bit eo = exp_ovf(a);
    access(1'b1, a, v, cyc);
    check(resp_ovf == eo, "R8", resp_ovf, eo);
    if (!eo) begin
      wset[a] = 1; spec_v[a] = 1; spec_d[a] = v;
      trk_on[(a>>2)&7] = 1; trk_tag[(a>>2)&7] = a >> 5;
    end
  endtask

  task automatic op_coh(input bit ex, input int a, input string rq);
    logic [1:0] ek = exp_kind(ex, a);
    @(negedge clk);
    coh_valid = 1; coh_excl = ex; coh_addr = AW'(a);
    @(negedge clk);
    coh_valid = 0;
    check(conf_valid == (ek != 0) && (ek == 0 || conf_kind == ek), rq,
          {conf_valid, conf_kind}, {ek != 0, ek});
  endtask

  task automatic op_end(input bit abort);
    @(negedge clk);
    if (abort) tx_abort = 1; else tx_commit = 1;
    @(negedge clk);
    tx_abort = 0; tx_commit = 0;
    for (int a = 0; a < POOL; a++) begin
      if (!abort && spec_v[a]) arch[a] = spec_d[a];
      spec_v[a] = 0; rset[a] = 0; wset[a] = 0;
    end
    for (int i = 0; i < 8; i++) trk_on[i] = 0;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin : main
    int cyc, f0, w0;
    void'($urandom(32'd2024));
    for (int a = 0; a < MEMW; a++) mem_img[a] = 32'hC0DE0000 + 32'(a * 7);
    for (int a = 0; a < POOL; a++) begin
      arch[a] = mem_img[a]; spec_v[a] = 0; rset[a] = 0; wset[a] = 0;
    end
    for (int i = 0; i < 8; i++) begin trk_on[i] = 0; trk_tag[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12: reset state
    check(!resp_valid && !mem_req && !conf_valid, "R12", {resp_valid, mem_req, conf_valid}, 0);
    op_coh(1'b1, 5, "R12");

    // R9: first load misses, line address requested
    f0 = fills;
    op_load(5, "R9", cyc);
    check(fills == f0 + 1 && last_fill_line == 1, "R9", last_fill_line, 1);
    // R11: hit latency one cycle
    f0 = fills;
    op_load(5, "R11", cyc);
    check(cyc == 1, "R11", cyc, 1);
    check(fills == f0, "R11", fills, f0);
    // R4 / R1
    op_coh(1'b0, 5, "R4");
    op_coh(1'b1, 5, "R1");
    // R2 / R3
    op_store(6, 32'hDEAD0006, cyc);
    op_coh(1'b0, 6, "R2");
    op_coh(1'b1, 6, "R3");
    op_load(6, "R2", cyc);
    // R5: no match
    op_coh(1'b1, 7, "R5");
    op_coh(1'b1, 32'h25, "R5");
    op_coh(1'b0, 32'h60, "R5");
    f0 = fills;
    op_load(5, "R5", cyc);
    check(fills == f0 && cyc == 1, "R5", fills, f0);
    // R8: conflicting index with tracked line
    f0 = fills;
    op_load(32'h25, "R8", cyc);
    check(fills == f0, "R8", fills, f0);
    op_coh(1'b1, 5, "R8");
    // R6: commit clears tracking, no writeback at commit
    w0 = wbs;
    op_end(1'b0);
    op_coh(1'b1, 6, "R6");
    op_coh(1'b0, 6, "R6");
    check(wbs == w0, "R6", wbs, w0);
    // R10: first touch of committed dirty line cleans it
    f0 = fills;
    op_load(6, "R10", cyc);
    check(fills == f0 + 1 && wbs == w0 + 1 && last_wb_line == 1, "R10", last_wb_line, 1);
    check(mem_img[6] == 32'hDEAD0006, "R6", mem_img[6], 32'hDEAD0006);
    // R7: abort invalidates and refetches
    op_store(9, 32'hBEEF0009, cyc);
    op_load(32'h29, "R8", cyc);
    op_end(1'b1);
    op_coh(1'b0, 9, "R7");
    f0 = fills;
    op_load(9, "R7", cyc);
    check(fills == f0 + 1, "R7", fills, f0 + 1);
    f0 = fills;
    op_load(5, "R7", cyc);
    check(fills == f0 + 1, "R7", fills, f0 + 1);
    // R9: dirty victim written back on eviction
    op_store(12, 32'h1234000C, cyc);
    op_end(1'b0);
    w0 = wbs;
    op_load(32'h2C, "R9", cyc);
    check(wbs == w0 + 1 && last_wb_line == 3 && mem_img[12] == 32'h1234000C, "R9", last_wb_line, 3);
    op_end(1'b0);

    // constrained random mix
    for (int n = 0; n < 800; n++) begin
      int sel = int'($urandom % 100);
      int a = int'($urandom % POOL);
      if (sel < 35) op_load(a, "R1", cyc);
      else if (sel < 65) op_store(a, $urandom, cyc);
      else if (sel < 88) op_coh(1'($urandom % 2), a, "R4");
      else if (sel < 95) op_end(1'b0);
      else op_end(1'b1);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule